// File: doc/BRIEF.md
# PLL Recalibration Sequencer

This block drives a recalibration of one PLL through a memory-mapped reconfiguration bus. The bus register file, the calibration engine and the analog PLL all sit outside it. A one-cycle start pulse launches the sequence. The sequencer first claims the bus by writing the user ownership code into a two-bit field of the ownership register. It waits for the bus to grant access, then sets the trigger bit of the calibration control register. It then passes the bus to the calibration engine by writing the engine code into the same field. Last, it watches a calibration-busy input until the engine reports that it has finished.

When the check option is sampled high together with start, the sequencer claims the bus again after calibration and reads the status register. It latches that word on an output and gives the bus back to the engine. When the option is low, it finishes as soon as calibration ends. Every register update is a read-modify-write, so bits outside the target field keep their values. The same sequencer serves a fractional PLL or a clock-data-recovery PLL: only the register space behind the bus differs.

Top module: `pll_recal_seq`

## Requirements
- R1: After reset, bus read and write strobes, busy, done and the status output are all low or zero.
- R2: To claim the bus, the block reads register 0x0, then writes back the same word with bits [1:0] replaced by code 2 (user owns the bus). All other bits are unchanged.
- R3: After each claim write, the block issues no bus access until it has sampled bus waitrequest low with no transfer in flight.
- R4: To trigger calibration, the block reads register 0x100 and writes it back with bit 1 set. All other bits are unchanged.
- R5: To hand the bus to the engine, the block reads register 0x0 and writes it back with bits [1:0] replaced by code 3 (engine owns the bus). All other bits are unchanged.
- R6: After the hand-over write, the block waits SETTLE_CYC cycles before it samples cal_busy. It ends the calibration wait only on a sampled low cal_busy, and it issues no bus access while it waits.
- R7: With the check option set, calibration is followed by a claim (as in R2 and R3), a read of register 0x101 and a hand-over (as in R5). status_o then holds the word read from 0x101.
- R8: With the check option clear, the sequence ends right after calibration, with exactly six bus transfers, and status_o keeps its previous value.
- R9: Read and write are never high together. While waitrequest is high during a transfer, read, write, address and writedata stay unchanged. A transfer counts as complete only on a cycle with waitrequest low.
- R10: busy_o rises in the cycle after start is sampled. done_o is high for exactly one cycle at the end, and busy_o is low in the cycle after it.
- R11: A start pulse that arrives while a sequence is running is ignored: the running sequence is neither restarted nor lengthened by extra transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Pulse that launches a recalibration |
| chk_i | input | 1 | Sampled with start: read back the status word at the end |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_wr_o | output | 1 | Bus write strobe |
| bus_rd_o | output | 1 | Bus read strobe |
| bus_wdata_o | output | DATA_W | Bus write data |
| bus_rdata_i | input | DATA_W | Bus read data, valid when waitrequest is low |
| bus_wait_i | input | 1 | Bus waitrequest |
| cal_busy_i | input | 1 | High while the engine calibrates |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| status_o | output | DATA_W | Last status word read back |

## Verification
If the sequencer stalls in the wrong state, the ports show it within a few cycles. Either an access appears while the grant is still pending or calibration is running, or the transfer count and order differ from the expected list of addresses and data. A wrong read-modify-write value shows up as a mismatched write word on the same transfer where it happens. A premature completion shows up as done rising while the modelled engine is still busy. A lost or stale status latch appears on status_o in the cycle after done.

// File: rtl/pll_recal_pkg.sv
package pll_recal_pkg;

   typedef enum logic [4:0] {
      S_IDLE,
      S_OWN1_RD,
      S_OWN1_WR,
      S_GRANT1,
      S_TRIG_RD,
      S_TRIG_WR,
      S_REL1_RD,
      S_REL1_WR,
      S_SETTLE,
      S_CAL,
      S_OWN2_RD,
      S_OWN2_WR,
      S_GRANT2,
      S_STAT_RD,
      S_REL2_RD,
      S_REL2_WR,
      S_FIN
   } seq_state_e;

   localparam logic [1:0] CODE_USER   = 2'd2;
   localparam logic [1:0] CODE_ENGINE = 2'd3;

endpackage

// File: rtl/recal_bus_port.sv
module recal_bus_port #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_go_i,
   input  logic              cmd_wr_i,
   input  logic [ADDR_W-1:0] cmd_addr_i,
   input  logic [DATA_W-1:0] cmd_wdata_i,
   input  logic              bus_wait_i,
   input  logic [DATA_W-1:0] bus_rdata_i,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic              bus_wr_o,
   output logic              bus_rd_o,
   output logic [DATA_W-1:0] bus_wdata_o,
   output logic              xfer_done_o,
   output logic [DATA_W-1:0] xfer_rdata_o,
   output logic              active_o
);

   logic active;
   assign active   = bus_rd_o | bus_wr_o;
   assign active_o = active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_addr_o   <= '0;
         bus_wr_o     <= 1'b0;
         bus_rd_o     <= 1'b0;
         bus_wdata_o  <= '0;
         xfer_done_o  <= 1'b0;
         xfer_rdata_o <= '0;
      end else begin
         xfer_done_o <= 1'b0;
         if (active) begin
            if (!bus_wait_i) begin
               bus_rd_o    <= 1'b0;
               bus_wr_o    <= 1'b0;
               xfer_done_o <= 1'b1;
               if (bus_rd_o) begin
                  xfer_rdata_o <= bus_rdata_i;
               end
            end
         end else if (cmd_go_i) begin
            bus_addr_o  <= cmd_addr_i;
            bus_wdata_o <= cmd_wdata_i;
            bus_wr_o    <= cmd_wr_i;
            bus_rd_o    <= ~cmd_wr_i;
         end
      end
   end

   assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (active && bus_wait_i) |=> ($stable(bus_rd_o) && $stable(bus_wr_o) &&
                                  $stable(bus_addr_o) && $stable(bus_wdata_o)));

   assert_rd_wr_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd_o && bus_wr_o));

   assert_done_needs_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done_o |-> ($past(active) && !$past(bus_wait_i)));

endmodule

// File: rtl/recal_seq_ctrl.sv
module recal_seq_ctrl
   import pll_recal_pkg::*;
#(
   parameter int ADDR_W     = 10,
   parameter int DATA_W     = 32,
   parameter int OWN_ADDR   = 'h000,
   parameter int TRIG_ADDR  = 'h100,
   parameter int STAT_ADDR  = 'h101,
   parameter int OWN_LSB    = 0,
   parameter int TRIG_BIT   = 1,
   parameter int SETTLE_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              chk_i,
   input  logic              bus_wait_i,
   input  logic              cal_busy_i,
   input  logic              port_active_i,
   input  logic              xfer_done_i,
   input  logic [DATA_W-1:0] xfer_rdata_i,
   output logic              cmd_go_o,
   output logic              cmd_wr_o,
   output logic [ADDR_W-1:0] cmd_addr_o,
   output logic [DATA_W-1:0] cmd_wdata_o,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] status_o
);

   localparam int SW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
   localparam logic [ADDR_W-1:0] A_OWN  = ADDR_W'(OWN_ADDR);
   localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(TRIG_ADDR);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

   seq_state_e state;
   logic       pend;
   logic       chk_q;
   logic       settle_last;
   logic       bus_state;

   function automatic logic [DATA_W-1:0] put_code(input logic [DATA_W-1:0] v,
                                                  input logic [1:0] code);
      logic [DATA_W-1:0] r;
      r = v;
      r[OWN_LSB +: 2] = code;
      return r;
   endfunction

   generate
      if (SETTLE_CYC == 1) begin : g_settle_one
         assign settle_last = 1'b1;
      end else begin : g_settle_cnt
         logic [SW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n || state != S_SETTLE) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         assign settle_last = (cnt == SW'(SETTLE_CYC - 1));
      end
   endgenerate

   always_comb begin
      bus_state   = 1'b1;
      cmd_wr_o    = 1'b0;
      cmd_addr_o  = A_OWN;
      cmd_wdata_o = '0;
      unique case (state)
         S_OWN1_RD, S_OWN2_RD, S_REL1_RD, S_REL2_RD: begin
            cmd_addr_o = A_OWN;
         end
         S_OWN1_WR, S_OWN2_WR: begin
            cmd_wr_o    = 1'b1;
            cmd_wdata_o = put_code(xfer_rdata_i, CODE_USER);
         end
         S_REL1_WR, S_REL2_WR: begin
            cmd_wr_o    = 1'b1;
            cmd_wdata_o = put_code(xfer_rdata_i, CODE_ENGINE);
         end
         S_TRIG_RD: begin
            cmd_addr_o = A_TRIG;
         end
         S_TRIG_WR: begin
            cmd_wr_o    = 1'b1;
            cmd_addr_o  = A_TRIG;
            cmd_wdata_o = xfer_rdata_i | (DATA_W'(1) << TRIG_BIT);
         end
         S_STAT_RD: begin
            cmd_addr_o = A_STAT;
         end
         default: begin
            bus_state = 1'b0;
         end
      endcase
      cmd_go_o = bus_state && !pend;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         pend     <= 1'b0;
         chk_q    <= 1'b0;
         status_o <= '0;
      end else begin
         if (bus_state) begin
            if (!pend) begin
               pend <= 1'b1;
            end else if (xfer_done_i) begin
               pend <= 1'b0;
               unique case (state)
                  S_OWN1_RD: state <= S_OWN1_WR;
                  S_OWN1_WR: state <= S_GRANT1;
                  S_TRIG_RD: state <= S_TRIG_WR;
                  S_TRIG_WR: state <= S_REL1_RD;
                  S_REL1_RD: state <= S_REL1_WR;
                  S_REL1_WR: state <= S_SETTLE;
                  S_OWN2_RD: state <= S_OWN2_WR;
                  S_OWN2_WR: state <= S_GRANT2;
                  S_STAT_RD: begin
                     status_o <= xfer_rdata_i;
                     state    <= S_REL2_RD;
                  end
                  S_REL2_RD: state <= S_REL2_WR;
                  default:   state <= S_FIN;
               endcase
            end
         end else begin
            unique case (state)
               S_IDLE: begin
                  if (start_i) begin
                     chk_q <= chk_i;
                     state <= S_OWN1_RD;
                  end
               end
               S_GRANT1: if (!bus_wait_i) state <= S_TRIG_RD;
               S_GRANT2: if (!bus_wait_i) state <= S_STAT_RD;
               S_SETTLE: if (settle_last) state <= S_CAL;
               S_CAL: begin
                  if (!cal_busy_i) begin
                     state <= chk_q ? S_OWN2_RD : S_FIN;
                  end
               end
               default: state <= S_IDLE;
            endcase
         end
      end
   end

   assign busy_o = (state != S_IDLE);
   assign done_o = (state == S_FIN);

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_then_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);

   assert_quiet_during_cal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_SETTLE || state == S_CAL) |-> !port_active_i);

   assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o && start_i) |=> busy_o);

   assert_grant_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == S_GRANT1 || state == S_GRANT2) && bus_wait_i) |=> !port_active_i);

endmodule

// File: rtl/pll_recal_seq.sv
module pll_recal_seq #(
   parameter int ADDR_W     = 10,
   parameter int DATA_W     = 32,
   parameter int OWN_ADDR   = 'h000,
   parameter int TRIG_ADDR  = 'h100,
   parameter int STAT_ADDR  = 'h101,
   parameter int OWN_LSB    = 0,
   parameter int TRIG_BIT   = 1,
   parameter int SETTLE_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              chk_i,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic              bus_wr_o,
   output logic              bus_rd_o,
   output logic [DATA_W-1:0] bus_wdata_o,
   input  logic [DATA_W-1:0] bus_rdata_i,
   input  logic              bus_wait_i,
   input  logic              cal_busy_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] status_o
);

   initial begin
      assert (OWN_LSB >= 0 && OWN_LSB + 2 <= DATA_W)
         else $error("ownership field outside data word");
      assert (TRIG_BIT >= 0 && TRIG_BIT < DATA_W)
         else $error("trigger bit outside data word");
      assert (SETTLE_CYC >= 1) else $error("settle delay must be at least one cycle");
      assert (STAT_ADDR < (1 << ADDR_W) && TRIG_ADDR < (1 << ADDR_W) && OWN_ADDR < (1 << ADDR_W))
         else $error("register offset does not fit the address width");
   end

   logic              cmd_go;
   logic              cmd_wr;
   logic [ADDR_W-1:0] cmd_addr;
   logic [DATA_W-1:0] cmd_wdata;
   logic              xfer_done;
   logic [DATA_W-1:0] xfer_rdata;
   logic              port_active;

   recal_bus_port #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_port (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_go_i     (cmd_go),
      .cmd_wr_i     (cmd_wr),
      .cmd_addr_i   (cmd_addr),
      .cmd_wdata_i  (cmd_wdata),
      .bus_wait_i   (bus_wait_i),
      .bus_rdata_i  (bus_rdata_i),
      .bus_addr_o   (bus_addr_o),
      .bus_wr_o     (bus_wr_o),
      .bus_rd_o     (bus_rd_o),
      .bus_wdata_o  (bus_wdata_o),
      .xfer_done_o  (xfer_done),
      .xfer_rdata_o (xfer_rdata),
      .active_o     (port_active)
   );

   recal_seq_ctrl #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .OWN_ADDR   (OWN_ADDR),
      .TRIG_ADDR  (TRIG_ADDR),
      .STAT_ADDR  (STAT_ADDR),
      .OWN_LSB    (OWN_LSB),
      .TRIG_BIT   (TRIG_BIT),
      .SETTLE_CYC (SETTLE_CYC)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .chk_i         (chk_i),
      .bus_wait_i    (bus_wait_i),
      .cal_busy_i    (cal_busy_i),
      .port_active_i (port_active),
      .xfer_done_i   (xfer_done),
      .xfer_rdata_i  (xfer_rdata),
      .cmd_go_o      (cmd_go),
      .cmd_wr_o      (cmd_wr),
      .cmd_addr_o    (cmd_addr),
      .cmd_wdata_o   (cmd_wdata),
      .busy_o        (busy_o),
      .done_o        (done_o),
      .status_o      (status_o)
   );

   assert_no_idle_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !(bus_rd_o || bus_wr_o));

endmodule

// File: tb/pll_recal_seq_tb.sv
module pll_recal_seq_tb_top;

   localparam int AW = 10;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          chk = 1'b0;
   logic [AW-1:0] addr;
   logic          wr, rd;
   logic [DW-1:0] wdata;
   logic [DW-1:0] rdata;
   logic          bwait;
   logic          cal_busy;
   logic          busy, done;
   logic [DW-1:0] status;

   always #10 clk = ~clk;

   pll_recal_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .chk_i(chk),
      .bus_addr_o(addr), .bus_wr_o(wr), .bus_rd_o(rd), .bus_wdata_o(wdata),
      .bus_rdata_i(rdata), .bus_wait_i(bwait), .cal_busy_i(cal_busy),
      .busy_o(busy), .done_o(done), .status_o(status)
   );

   // ---------------- bus and engine model ----------------
   int            m_w, m_g, m_b, m_d;
   logic [DW-1:0] m_stat_val;
   logic          ld_req = 1'b0;
   logic [DW-1:0] ld_own, ld_trig;
   logic [DW-1:0] reg_own, reg_trig, reg_stat;
   int            wcnt, gcnt, ccnt;
   logic          pend_d;
   logic          cal_b;
   logic          cal_fin;

   assign cal_busy = cal_b;
   assign bwait = (rd || wr) ? (wcnt < m_w) : (gcnt != 0);

   always_comb begin
      case (addr)
         10'h000: rdata = reg_own;
         10'h100: rdata = reg_trig;
         10'h101: rdata = reg_stat;
         default: rdata = '0;
      endcase
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         wcnt <= 0; gcnt <= 0; ccnt <= 0; pend_d <= 1'b0; cal_b <= 1'b0;
         cal_fin <= 1'b0; reg_own <= '0; reg_trig <= '0; reg_stat <= '0;
      end else if (ld_req) begin
         reg_own <= ld_own; reg_trig <= ld_trig; reg_stat <= '0;
         cal_fin <= 1'b0; gcnt <= 0; wcnt <= 0;
      end else begin
         if (gcnt != 0) gcnt <= gcnt - 1;
         if (rd || wr) begin
            if (bwait) wcnt <= wcnt + 1;
            else wcnt <= 0;
         end
         if (wr && !bwait) begin
            if (addr == 10'h000) begin
               reg_own <= wdata;
               if (wdata[1:0] == 2'd2) gcnt <= m_g;
               if (wdata[1:0] == 2'd3 && reg_trig[1]) begin
                  if (m_d == 0) begin cal_b <= 1'b1; ccnt <= m_b; end
                  else pend_d <= 1'b1;
               end
            end else if (addr == 10'h100) begin
               reg_trig <= wdata;
            end
         end
         if (pend_d) begin
            pend_d <= 1'b0; cal_b <= 1'b1; ccnt <= m_b;
         end else if (cal_b) begin
            if (ccnt <= 1) begin
               cal_b <= 1'b0; reg_trig[1] <= 1'b0; reg_stat <= m_stat_val; cal_fin <= 1'b1;
            end else ccnt <= ccnt - 1;
         end
      end
   end

   // ---------------- monitor ----------------
   logic          mon_clr = 1'b0;
   int            n_xfer, n_done, v_grant, v_cal, v_hold, v_early, v_both;
   logic          t_wr  [0:15];
   logic [AW-1:0] t_addr[0:15];
   logic [DW-1:0] t_data[0:15];
   logic          p_hold;
   logic          p_rd, p_wr;
   logic [AW-1:0] p_addr;
   logic [DW-1:0] p_wdata;

   always @(negedge clk) begin
      if (mon_clr) begin
         n_xfer = 0; n_done = 0; v_grant = 0; v_cal = 0; v_hold = 0; v_early = 0; v_both = 0;
         p_hold = 1'b0;
      end else if (rst_n) begin
         if (p_hold && (rd != p_rd || wr != p_wr || addr != p_addr || wdata != p_wdata)) v_hold++;
         if (rd && wr) v_both++;
         if ((rd || wr) && gcnt != 0) v_grant++;
         if ((rd || wr) && (cal_b || pend_d)) v_cal++;
         if (done) begin
            n_done++;
            if (cal_b || pend_d || !cal_fin) v_early++;
         end
         if ((rd || wr) && !bwait && n_xfer < 16) begin
            t_wr[n_xfer]   = wr;
            t_addr[n_xfer] = addr;
            t_data[n_xfer] = wr ? wdata : rdata;
            n_xfer++;
         end
         p_hold = (rd || wr) && bwait;
         p_rd = rd; p_wr = wr; p_addr = addr; p_wdata = wdata;
      end
   end

   // ---------------- checking ----------------
   int n_checks = 0;
   int n_fail = 0;
   int cycles = 0;

   task automatic check(input logic ok, input string req, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
         $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   function automatic logic [DW-1:0] code(input logic [DW-1:0] v, input logic [1:0] c);
      return {v[DW-1:2], c};
   endfunction

   logic [DW-1:0] last_status = '0;

   task automatic run_case(input int idx, input logic c, input int w, input int g,
                           input int b, input int d, input logic mid);
      logic          e_wr  [0:15];
      logic [AW-1:0] e_addr[0:15];
      logic [DW-1:0] e_data[0:15];
      int            ne;
      int            tmo;
      logic [DW-1:0] i_own, i_trig, e1, e2, e3, e4, sv;
      i_own  = 32'h1234_5670 ^ (idx * 32'h0101_0103);
      i_trig = 32'h8000_00F0 ^ (idx * 32'h0002_0007);
      sv     = 32'hA500_0000 ^ (idx * 32'h0001_0011);
      e1 = code(i_own, 2'd2); e2 = code(e1, 2'd3); e3 = code(e2, 2'd2); e4 = code(e3, 2'd3);
      ne = 0;
      e_wr[ne] = 0; e_addr[ne] = 10'h000; e_data[ne] = i_own;          ne++;
      e_wr[ne] = 1; e_addr[ne] = 10'h000; e_data[ne] = e1;             ne++; // R2
      e_wr[ne] = 0; e_addr[ne] = 10'h100; e_data[ne] = i_trig;         ne++;
      e_wr[ne] = 1; e_addr[ne] = 10'h100; e_data[ne] = i_trig | 32'h2; ne++; // R4
      e_wr[ne] = 0; e_addr[ne] = 10'h000; e_data[ne] = e1;             ne++;
      e_wr[ne] = 1; e_addr[ne] = 10'h000; e_data[ne] = e2;             ne++; // R5
      if (c) begin // R7
         e_wr[ne] = 0; e_addr[ne] = 10'h000; e_data[ne] = e2; ne++;
         e_wr[ne] = 1; e_addr[ne] = 10'h000; e_data[ne] = e3; ne++;
         e_wr[ne] = 0; e_addr[ne] = 10'h101; e_data[ne] = sv; ne++;
         e_wr[ne] = 0; e_addr[ne] = 10'h000; e_data[ne] = e3; ne++;
         e_wr[ne] = 1; e_addr[ne] = 10'h000; e_data[ne] = e4; ne++;
      end

      @(negedge clk);
      m_w = w; m_g = g; m_b = b; m_d = d; m_stat_val = sv;
      ld_own = i_own; ld_trig = i_trig; ld_req = 1'b1; mon_clr = 1'b1;
      @(negedge clk);
      ld_req = 1'b0; mon_clr = 1'b0;
      start = 1'b1; chk = c;
      @(negedge clk);
      start = 1'b0; chk = 1'b0;
      check(busy == 1'b1, "R10 busy after start", {31'b0, busy}, 32'h1);
      if (mid) begin
         repeat (4) @(negedge clk);
         start = 1'b1; chk = ~c;
         @(negedge clk);
         start = 1'b0; chk = 1'b0;
      end
      tmo = 0;
      while (n_done == 0 && tmo < 3000) begin
         @(negedge clk);
         tmo++;
      end
      check(tmo < 3000, "R10 sequence ends", tmo, 0);
      repeat (3) @(negedge clk);
      check(n_done == 1, "R10 done width", n_done, 1);
      check(busy == 1'b0, "R10 idle after done", {31'b0, busy}, 0);
      check(n_xfer == ne, mid ? "R11 transfer count" : (c ? "R7 transfer count" : "R8 transfer count"),
            n_xfer, ne);
      for (int k = 0; k < 16; k++) begin
         if (k < ne && k < n_xfer) begin
            check(t_wr[k] == e_wr[k] && t_addr[k] == e_addr[k], "R2 R4 R5 transfer kind",
                  {t_wr[k], 21'b0, t_addr[k]}, {e_wr[k], 21'b0, e_addr[k]});
            check(t_data[k] == e_data[k], "R2 R4 R5 transfer data", t_data[k], e_data[k]);
         end
      end
      check(v_grant == 0, "R3 access during grant wait", v_grant, 0);
      check(v_cal == 0, "R6 access during calibration", v_cal, 0);
      check(v_early == 0, "R6 done before calibration end", v_early, 0);
      check(v_hold == 0, "R9 strobes changed under waitrequest", v_hold, 0);
      check(v_both == 0, "R9 read and write together", v_both, 0);
      if (c) begin
         check(status == sv, "R7 status latched", status, sv);
         last_status = sv;
      end else begin
         check(status == last_status, "R8 status kept", status, last_status);
      end
   endtask

   initial begin
      int idx;
      repeat (3) @(negedge clk);
      check(rd == 0 && wr == 0 && busy == 0 && done == 0 && status == 0, "R1 reset state",
            {27'b0, rd, wr, busy, done, |status}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(rd == 0 && wr == 0 && busy == 0, "R1 idle after reset", {29'b0, rd, wr, busy}, 0);
      idx = 0;
      for (int c = 0; c < 2; c++)
         for (int w = 0; w < 3; w++)
            for (int g = 0; g < 3; g++)
               for (int b = 1; b < 4; b++)
                  for (int d = 0; d < 2; d++) begin
                     run_case(idx, c[0], w, g, b, d, (idx % 4) == 1);
                     idx++;
                  end
      // back-to-back: skip-check run right after a checked run keeps status (R8)
      run_case(idx, 1'b1, 1, 1, 2, 0, 1'b0);
      run_case(idx + 1, 1'b0, 2, 2, 3, 1, 1'b0);
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule